// File: doc/BRIEF.md
# Register-Pair Signed Multiply/Divide Unit

This unit executes signed multiply and divide operations whose first operand is an even/odd pair of 32-bit registers. The caller reads both words of the pair and the second operand from its register file, raises `start` for one cycle, and then waits for the `done` pulse. When `done` is high, the unit may also assert write enables. The caller uses them to write `even_data` into the even register and `odd_data` into the odd register.

Multiply forms a 64-bit product from the odd word of the pair (the multiplicand) and the second operand (the multiplier). With `half_op` set, the multiplier is the sign-extended low 16 bits of the second operand. Divide treats the pair as a 64-bit signed dividend and divides it by a 32-bit signed divisor. Both operations iterate one bit per clock.

An odd register number is rejected with a specification exception. A zero divisor, or a quotient that does not fit in 32 signed bits, is rejected with a divide exception. In both cases the pair is not written.

Top module: `mdu_pair_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `even_we`, `odd_we`, `spec_exc` and `div_exc` are all low.
- R2: If `reg_num` bit 0 is 1 when `start` is accepted, `done` and `spec_exc` are high for one cycle after the second rising edge counted from the accepting edge. `div_exc` and both write enables stay low for either operation.
- R3: With `op_div`=0 (multiply), `{even_data, odd_data}` is the signed 64-bit product of `pair_odd` and `operand2`. The upper word goes to `even_data`. `pair_even` has no effect on the result. Both write enables pulse with `done`.
- R4: With `op_div`=0 and `half_op`=1, the multiplier is `operand2[15:0]` sign-extended to 32 bits. `operand2[31:16]` is ignored.
- R5: With `op_div`=1 (divide), the dividend is `{pair_even, pair_odd}` as a signed 64-bit value. `odd_data` receives the quotient, truncated toward zero. `even_data` receives the remainder, which carries the sign of the dividend. Both write enables pulse with `done`.
- R6: A divide by zero raises `div_exc` with `done` and writes nothing.
- R7: A divide whose quotient lies outside [-2^31, 2^31-1] raises `div_exc` and writes nothing. A quotient of exactly -2^31 is a valid result.
- R8: A valid request keeps `busy` high from the accepting edge until the 33rd edge after it. `done` is high for exactly the one cycle that follows that 33rd edge. `start` is ignored while `busy` is high.
- R9: With `op_div`=1, `half_op` has no effect: the divisor is always the full 32-bit `operand2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled when not busy |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| reg_num | input | 4 | First-operand register number; must be even |
| pair_even | input | 32 | Contents of the even register of the pair |
| pair_odd | input | 32 | Contents of the odd register of the pair |
| operand2 | input | 32 | Multiplier or divisor |
| half_op | input | 1 | Multiply only: use sign-extended low halfword as multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| even_data | output | 32 | Product high word or remainder |
| odd_data | output | 32 | Product low word or quotient |
| even_we | output | 1 | Write enable for the even register |
| odd_we | output | 1 | Write enable for the odd register |
| spec_exc | output | 1 | Odd register number rejected |
| div_exc | output | 1 | Zero divisor or quotient overflow |

## Verification
Faults inside the unit reach the ports in different ways:

- **Iteration counter:** a counter that is off by one moves the `done` pulse away from the 33rd edge, so the per-cycle comparison of `busy` and `done` catches it on the first request.
- **Datapath:** a wrong sign fix-up or a lost iteration corrupts `even_data`/`odd_data` only at `done`. The test therefore covers each sign combination, the halfword multiplier and the extreme magnitudes.
- **Overflow detection:** a faulty check either writes a result it should block or raises `div_exc` falsely. It shows up in the same `done` cycle on the boundary divides around -2^31 and 2^31.

// File: rtl/mdu_pkg.sv
// Package: shared types for the register-pair multiply/divide unit.
// Assumes nothing beyond a single clock domain.
package mdu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mdu_state_t;
endpackage

// File: rtl/mdu_ctrl.sv
// Sequencer: accepts a request when idle, runs WIDTH iteration cycles,
// then one finish cycle. A rejected (odd register) request skips the
// iterations and goes straight to finish.
// Assumes start is a level sampled on the clock edge.
module mdu_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic skip,
    output logic load,
    output logic step,
    output logic fin,
    output logic busy
);
    import mdu_pkg::*;

    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    mdu_state_t state;
    logic [CNT_W-1:0] cnt;

    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);
    assign fin  = (state == ST_FIN);
    assign busy = (state != ST_IDLE);

    // Advance the state and the iteration count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= skip ? ST_FIN : ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8
    run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == LAST) |=> fin);
endmodule

// File: rtl/mdu_mul_step.sv
// One shift/add multiply iteration on unsigned magnitudes.
// acc_hi holds the partial product high word, acc_lo the remaining
// multiplier bits (shifted out LSB first) and the growing low word.
module mdu_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc_hi,
    input  logic [WIDTH-1:0] acc_lo,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH-1:0] hi_next,
    output logic [WIDTH-1:0] lo_next
);
    logic [WIDTH:0] sum;

    // Conditionally add the multiplicand, then shift the pair right.
    always_comb begin
        sum     = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
        hi_next = sum[WIDTH:1];
        lo_next = {sum[0], acc_lo[WIDTH-1:1]};
    end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division iteration on unsigned magnitudes.
// Assumes rem < dvs on entry, which keeps the remainder in WIDTH bits.
module mdu_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem,
    input  logic [WIDTH-1:0] quo,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH-1:0] rem_next,
    output logic [WIDTH-1:0] quo_next
);
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;
    logic           fits;

    // Shift in the next dividend bit and subtract when the divisor fits.
    always_comb begin
        trial    = {rem, quo[WIDTH-1]};
        diff     = trial - {1'b0, dvs};
        fits     = trial >= {1'b0, dvs};
        rem_next = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
        quo_next = {quo[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/mdu_pair_unit.sv
// Register-pair signed multiply/divide unit (top).
// Multiply: pair_odd * operand2 (or its sign-extended low half) -> pair.
// Divide: {pair_even,pair_odd} / operand2 -> remainder even, quotient odd.
// Works on magnitudes and fixes signs in the finish cycle.
// Assumes the caller holds no expectations on data outputs unless a
// write enable is high.
module mdu_pair_unit #(
    parameter int WIDTH    = 32,
    parameter int REG_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op_div,
    input  logic [REG_BITS-1:0] reg_num,
    input  logic [WIDTH-1:0]    pair_even,
    input  logic [WIDTH-1:0]    pair_odd,
    input  logic [WIDTH-1:0]    operand2,
    input  logic                half_op,
    output logic                busy,
    output logic                done,
    output logic [WIDTH-1:0]    even_data,
    output logic [WIDTH-1:0]    odd_data,
    output logic                even_we,
    output logic                odd_we,
    output logic                spec_exc,
    output logic                div_exc
);
    localparam int HALF_W = WIDTH / 2;
    localparam int DBL_W  = 2 * WIDTH;
    localparam logic [WIDTH-1:0] MIN_MAG = {1'b1, {(WIDTH-1){1'b0}}};

    logic load, step, fin;

    mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .skip(reg_num[0]),
        .load(load), .step(step), .fin(fin), .busy(busy)
    );

    // Operation state captured at load.
    logic             div_q, spec_q, pre_exc_q, neg_a_q, neg_b_q;
    logic [WIDTH-1:0] acc_hi, acc_lo, opnd_q;

    // Load-time operand preparation.
    logic [WIDTH-1:0] mult_src, mag_mcand, mag_mult, mag_dvs;
    logic [DBL_W-1:0] dividend, mag_dvd;
    logic             sgn_a, sgn_b;

    // Build signed operands and their magnitudes for either operation.
    always_comb begin
        mult_src  = half_op ? {{(WIDTH-HALF_W){operand2[HALF_W-1]}}, operand2[HALF_W-1:0]}
                            : operand2;
        mag_mcand = pair_odd[WIDTH-1] ? -pair_odd : pair_odd;
        mag_mult  = mult_src[WIDTH-1] ? -mult_src : mult_src;
        mag_dvs   = operand2[WIDTH-1] ? -operand2 : operand2;
        dividend  = {pair_even, pair_odd};
        mag_dvd   = dividend[DBL_W-1] ? -dividend : dividend;
        sgn_a     = op_div ? dividend[DBL_W-1] : pair_odd[WIDTH-1];
        sgn_b     = op_div ? operand2[WIDTH-1] : mult_src[WIDTH-1];
    end

    // Iteration datapaths.
    logic [WIDTH-1:0] mhi_n, mlo_n, drem_n, dquo_n;

    mdu_mul_step #(.WIDTH(WIDTH)) u_mul (
        .acc_hi(acc_hi), .acc_lo(acc_lo), .mcand(opnd_q),
        .hi_next(mhi_n), .lo_next(mlo_n)
    );

    mdu_div_step #(.WIDTH(WIDTH)) u_div (
        .rem(acc_hi), .quo(acc_lo), .dvs(opnd_q),
        .rem_next(drem_n), .quo_next(dquo_n)
    );

    // Capture operands on load and iterate while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= 1'b0;
            spec_q    <= 1'b0;
            pre_exc_q <= 1'b0;
            neg_a_q   <= 1'b0;
            neg_b_q   <= 1'b0;
            acc_hi    <= '0;
            acc_lo    <= '0;
            opnd_q    <= '0;
        end else if (load) begin
            div_q     <= op_div;
            spec_q    <= reg_num[0];
            neg_a_q   <= sgn_a;
            neg_b_q   <= sgn_b;
            if (op_div) begin
                acc_hi    <= mag_dvd[DBL_W-1:WIDTH];
                acc_lo    <= mag_dvd[WIDTH-1:0];
                opnd_q    <= mag_dvs;
                pre_exc_q <= (mag_dvs == '0) || (mag_dvd[DBL_W-1:WIDTH] >= mag_dvs);
            end else begin
                acc_hi    <= '0;
                acc_lo    <= mag_mult;
                opnd_q    <= mag_mcand;
                pre_exc_q <= 1'b0;
            end
        end else if (step) begin
            acc_hi <= div_q ? drem_n : mhi_n;
            acc_lo <= div_q ? dquo_n : mlo_n;
        end
    end

    // Finish-cycle sign fix-up and range check.
    logic [DBL_W-1:0] prod_mag, prod;
    logic [WIDTH-1:0] quo_s, rem_s;
    logic             q_neg, q_fits, bad_div;

    // Apply signs to the magnitudes and decide whether the quotient fits.
    always_comb begin
        prod_mag = {acc_hi, acc_lo};
        prod     = (neg_a_q ^ neg_b_q) ? -prod_mag : prod_mag;
        q_neg    = neg_a_q ^ neg_b_q;
        q_fits   = q_neg ? (acc_lo <= MIN_MAG) : !acc_lo[WIDTH-1];
        quo_s    = q_neg ? -acc_lo : acc_lo;
        rem_s    = neg_a_q ? -acc_hi : acc_hi;
        bad_div  = pre_exc_q || !q_fits;
    end

    // Register the result, the write enables and the exception flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            even_we   <= 1'b0;
            odd_we    <= 1'b0;
            spec_exc  <= 1'b0;
            div_exc   <= 1'b0;
            even_data <= '0;
            odd_data  <= '0;
        end else begin
            done     <= fin;
            spec_exc <= fin && spec_q;
            div_exc  <= fin && !spec_q && div_q && bad_div;
            even_we  <= fin && !spec_q && !(div_q && bad_div);
            odd_we   <= fin && !spec_q && !(div_q && bad_div);
            if (fin && !spec_q && !(div_q && bad_div)) begin
                even_data <= div_q ? rem_s : prod[DBL_W-1:WIDTH];
                odd_data  <= div_q ? quo_s : prod[WIDTH-1:0];
            end
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3
    we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_we || odd_we) |-> done);
    // R2
    spec_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_exc |-> (!even_we && !odd_we && !div_exc));
    // R6
    div_exc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_exc |-> (!even_we && !odd_we && done));
endmodule

// File: tb/mdu_pair_unit_test.sv
module mdu_pair_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [31:0] pair_even = '0, pair_odd = '0, operand2 = '0;
    logic        half_op = 1'b0;
    logic        busy, done, even_we, odd_we, spec_exc, div_exc;
    logic [31:0] even_data, odd_data;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R3";

    always #(CLK_PERIOD/2) clk = ~clk;

    mdu_pair_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .reg_num(reg_num), .pair_even(pair_even), .pair_odd(pair_odd),
        .operand2(operand2), .half_op(half_op), .busy(busy), .done(done),
        .even_data(even_data), .odd_data(odd_data), .even_we(even_we),
        .odd_we(odd_we), .spec_exc(spec_exc), .div_exc(div_exc)
    );

    // Behavioural reference model, updated on each rising edge.
    bit m_busy, m_done, m_we, m_spec, m_dexc;
    bit p_we, p_spec, p_dexc;
    int m_left = 0;
    logic [31:0] p_even, p_odd;

    always @(posedge clk) begin
        longint a, b, p, dd, dv, q, r;
        m_done = 0; m_we = 0; m_spec = 0; m_dexc = 0;
        if (!rst_n) begin
            m_busy = 0; m_left = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0; m_done = 1;
                m_we = p_we; m_spec = p_spec; m_dexc = p_dexc;
            end
        end else if (start) begin
            m_busy = 1;
            p_we = 0; p_spec = 0; p_dexc = 0; p_even = 'x; p_odd = 'x;
            if (reg_num[0]) begin
                p_spec = 1; m_left = 1;
            end else begin
                m_left = 33;
                if (!op_div) begin
                    a = longint'($signed(pair_odd));
                    b = half_op ? longint'($signed(operand2[15:0])) : longint'($signed(operand2));
                    p = a * b;
                    p_even = p[63:32]; p_odd = p[31:0]; p_we = 1;
                end else begin
                    dd = $signed({pair_even, pair_odd});
                    dv = longint'($signed(operand2));
                    if (dv == 0) p_dexc = 1;
                    else if (dd == 64'sh8000_0000_0000_0000 && dv == -1) p_dexc = 1;
                    else begin
                        q = dd / dv; r = dd % dv;
                        if (q > 64'sd2147483647 || q < -64'sd2147483648) p_dexc = 1;
                        else begin
                            p_even = r[31:0]; p_odd = q[31:0]; p_we = 1;
                        end
                    end
                end
            end
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            checks++;
            if ({busy, done, even_we, odd_we, spec_exc, div_exc} !==
                {m_busy, m_done, m_we, m_we, m_spec, m_dexc}) begin
                failures++;
                $display("FAIL R8/%s control: got busy=%b done=%b we=%b%b spec=%b dexc=%b exp %b %b %b%b %b %b",
                    cur_req, busy, done, even_we, odd_we, spec_exc, div_exc,
                    m_busy, m_done, m_we, m_we, m_spec, m_dexc);
            end
            if (m_done && m_we) begin
                checks++;
                if (even_data !== p_even || odd_data !== p_odd) begin
                    failures++;
                    $display("FAIL %s data: got %h_%h exp %h_%h",
                        cur_req, even_data, odd_data, p_even, p_odd);
                end
            end
        end
    end

    task automatic issue(input string req, input bit d, input logic [3:0] rn,
                         input logic [31:0] ev, input logic [31:0] od,
                         input logic [31:0] o2, input bit h);
        @(negedge clk);
        cur_req = req;
        op_div = d; reg_num = rn; pair_even = ev; pair_odd = od;
        operand2 = o2; half_op = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (36) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1: reset state
        checks++;
        if ({busy, done, even_we, odd_we, spec_exc, div_exc} !== 6'b0) begin
            failures++;
            $display("FAIL R1 reset: got %b exp 000000",
                {busy, done, even_we, odd_we, spec_exc, div_exc});
        end
        // R3: multiply sign combinations, pair_even ignored
        issue("R3", 0, 4'd2, 32'hDEAD_BEEF, 32'd7, -32'sd3, 0);
        issue("R3", 0, 4'd4, 32'h0, 32'h8000_0000, 32'h8000_0000, 0);
        issue("R3", 0, 4'd0, 32'h1234_5678, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
        issue("R3", 0, 4'd6, 32'h0, -32'sd12345, 32'd67890, 0);
        // R4: halfword multiplier
        issue("R4", 0, 4'd2, 32'h0, 32'd1000, 32'h0001_FFFF, 1);
        issue("R4", 0, 4'd8, 32'h0, -32'sd5, 32'hFFFF_7FFF, 1);
        // R2: odd register numbers
        issue("R2", 0, 4'd3, 32'h0, 32'd5, 32'd5, 0);
        issue("R2", 1, 4'd15, 32'h0, 32'd100, 32'd0, 0);
        // R5: divide sign cases
        issue("R5", 1, 4'd6, 32'h0, 32'd100, 32'd7, 0);
        issue("R5", 1, 4'd6, 32'hFFFF_FFFF, -32'sd100, 32'd7, 0);
        issue("R5", 1, 4'd6, 32'h0, 32'd100, -32'sd7, 0);
        issue("R5", 1, 4'd6, 32'hFFFF_FFFF, -32'sd100, -32'sd7, 0);
        issue("R5", 1, 4'd10, 32'h0000_0003, 32'h1234_5678, 32'h7654_3210, 0);
        // R6: zero divisor
        issue("R6", 1, 4'd0, 32'h0, 32'd55, 32'd0, 0);
        // R7: quotient range boundaries
        issue("R7", 1, 4'd0, 32'h0, 32'h8000_0000, 32'd1, 0);
        issue("R7", 1, 4'd0, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 0);
        issue("R7", 1, 4'd0, 32'h8000_0000, 32'h0, -32'sd1, 0);
        issue("R7", 1, 4'd0, 32'h0, 32'h7FFF_FFFF, 32'd1, 0);
        // R9: half flag ignored on divide
        issue("R9", 1, 4'd2, 32'h0, 32'd1_000_000, 32'h0001_0007, 1);
        // R8: start ignored while busy
        @(negedge clk);
        cur_req = "R8";
        op_div = 0; reg_num = 4'd2; pair_odd = 32'd9; operand2 = 32'd11;
        half_op = 0; start = 1'b1;
        @(negedge clk);
        pair_odd = 32'd123; operand2 = 32'd456; op_div = 1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule